// File: doc/BRIEF.md
# Tri-Level Serial Frame Receiver

This block decodes the single control pin of a digitally pulled oscillator from the device side. An analog front end outside the block compares the pin against two thresholds and hands over two synchronised flags: one for "above the high threshold" and one for "below the low threshold". When neither flag is set, the line is at its middle level. Each bit is a level excursion that then settles back to the middle: a high excursion means 1 and a low excursion means 0. There is no clock on the pin and no fixed baud rate. A bit is counted only once the line has come back to mid.

The recovered bits are gathered into frames of 40 bits, sent most significant bit first. Each frame holds a 16-bit preamble `0xFA0A`, an 8-bit register address and a 16-bit data value. Two pull registers are decoded. A write to the low register (0x07) only stages its bottom seven bits. A write to the high register (0x06) commits a new control word as a one-cycle pulse. The `wide_mode` input chooses between a 23-bit word and a 16-bit word. Frames that break the rules are thrown away, and the receiver then waits for the line to fall idle before it hunts for the next frame.

The bit slicer has four states. In `SL_MID` (idle) a level moves it to `SL_HI` or `SL_LO`. In `SL_HI` and `SL_LO`, a return to mid moves it to `SL_RET`, and a swap to the opposite level restarts the pulse. In `SL_RET`, `MID_MIN` mid cycles in a row emit a bit and return to `SL_MID`, while a fresh level drops the pending pulse as a glitch. The frame tracker also has four states. In `FR_IDLE` the first bit moves it to `FR_PRE`. At the 16th bit, `FR_PRE` goes to `FR_BODY` if the preamble matches and to `FR_DROP` if it does not. At the 24th bit, `FR_BODY` emits the frame and returns to `FR_IDLE`. From `FR_PRE`, `FR_BODY` or `FR_DROP`, an idle timeout returns the tracker to `FR_IDLE`.

Top module: `trilevel_frame_rx`

## Requirements
- R1: A high excursion followed by a settled return to mid decodes as bit 1. A low excursion followed by a settled return to mid decodes as bit 0. The flags encode high as `lvl_hi`=1, low as `lvl_lo`=1 and mid as both flags 0.
- R2: A bit is registered only after the line has stayed mid for `MID_MIN` consecutive cycles. If a new level arrives before that, the pending excursion is discarded as a glitch.
- R3: The first 16 bits of a frame must equal 0xFA0A, sent MSB first. On a mismatch the frame produces no commit, and the receiver accepts a new frame once the line has been idle for `IDLE_LIMIT` cycles.
- R4: After the preamble, a frame carries an 8-bit address and then 16 bits of data, both MSB first, for 40 bits in total.
- R5: A frame addressed to 0x07 stores data bits [6:0] in the staged low register and produces no commit.
- R6: A frame addressed to 0x06 raises `commit_valid` for exactly one cycle. In wide mode (`wide_mode`=1), `commit_word` is {data[15:0], staged[6:0]}.
- R7: In narrow mode (`wide_mode`=0), a commit carries `commit_word` = {7'b0, data[15:0]}.
- R8: If the line stays mid for `IDLE_LIMIT` cycles partway through a frame, the partial frame is discarded with no commit, and the next complete frame is decoded normally.
- R9: Frames addressed anywhere other than 0x06 and 0x07 produce no commit and leave the staged low register unchanged.
- R10: After reset, `commit_valid` is 0, `commit_word` is 0 and the staged low register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_hi | input | 1 | Line above the high threshold (synchronised) |
| lvl_lo | input | 1 | Line below the low threshold (synchronised) |
| wide_mode | input | 1 | 1 selects a 23-bit control word, 0 selects 16 bits |
| commit_valid | output | 1 | One-cycle pulse when a new control word is committed |
| commit_word | output | 23 | Control word of the most recent commit |

## Verification
A slicer stuck in a wrong state, or with a miscounted settle counter, either loses or duplicates a bit. That shifts every later field of the frame, so the very next commit to 0x06 comes out with a wrong word or does not appear at all. A faulty preamble check or idle timeout shows up as a commit where none should occur, or as a missing commit for the next good frame. A corrupted staged register is only seen at the next wide-mode commit, in bits [6:0]. Every such fault therefore reaches the ports within one frame time, about 40 symbol periods.

// File: rtl/trl_pkg.sv
package trl_pkg;
    localparam int PRE_W     = 16;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int LO_W      = 7;
    localparam int BODY_W    = ADDR_W + DATA_W;
    localparam int WORD_W    = DATA_W + LO_W;
    localparam logic [PRE_W-1:0]  SYNC_WORD = 16'hFA0A;
    localparam logic [ADDR_W-1:0] REG_HI    = 8'h06;
    localparam logic [ADDR_W-1:0] REG_LO    = 8'h07;

    typedef enum logic [1:0] {SL_MID, SL_HI, SL_LO, SL_RET} slice_st_t;
    typedef enum logic [1:0] {FR_IDLE, FR_PRE, FR_BODY, FR_DROP} frame_st_t;
endpackage

// File: rtl/trl_bit_slicer.sv
module trl_bit_slicer
    import trl_pkg::*;
#(
    parameter int MID_MIN    = 4,
    parameter int IDLE_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_hi,
    input  logic lvl_lo,
    output logic bit_stb,
    output logic bit_val,
    output logic idle_tick
);
    localparam int CW = $clog2(MID_MIN + 1);
    localparam int IW = $clog2(IDLE_LIMIT + 1);

    slice_st_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [IW-1:0] idle_cnt, idle_n;
    logic pend, pend_n, stb_n, tick_n;
    logic is_hi, is_lo, is_mid;

    assign is_hi  = lvl_hi;
    assign is_lo  = lvl_lo && !lvl_hi;
    assign is_mid = !lvl_hi && !lvl_lo;

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        pend_n = pend;
        stb_n  = 1'b0;
        unique case (st)
            SL_MID: begin
                if (is_hi)      begin st_n = SL_HI; pend_n = 1'b1; end
                else if (is_lo) begin st_n = SL_LO; pend_n = 1'b0; end
            end
            SL_HI: begin
                if (is_mid)     begin st_n = SL_RET; cnt_n = CW'(1); end
                else if (is_lo) begin st_n = SL_LO; pend_n = 1'b0; end
            end
            SL_LO: begin
                if (is_mid)     begin st_n = SL_RET; cnt_n = CW'(1); end
                else if (is_hi) begin st_n = SL_HI; pend_n = 1'b1; end
            end
            SL_RET: begin
                if (is_hi)      begin st_n = SL_HI; pend_n = 1'b1; end
                else if (is_lo) begin st_n = SL_LO; pend_n = 1'b0; end
                else if (cnt == CW'(MID_MIN - 1)) begin
                    st_n  = SL_MID;
                    stb_n = 1'b1;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            default: st_n = SL_MID;
        endcase
    end

    always_comb begin
        idle_n = '0;
        tick_n = 1'b0;
        if (st == SL_MID && is_mid) begin
            idle_n = (idle_cnt == IW'(IDLE_LIMIT)) ? idle_cnt : idle_cnt + IW'(1);
            tick_n = (idle_cnt == IW'(IDLE_LIMIT - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SL_MID;
            cnt      <= '0;
            pend     <= 1'b0;
            idle_cnt <= '0;
        end else begin
            st       <= st_n;
            cnt      <= cnt_n;
            pend     <= pend_n;
            idle_cnt <= idle_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_stb   <= 1'b0;
            bit_val   <= 1'b0;
            idle_tick <= 1'b0;
        end else begin
            bit_stb   <= stb_n;
            bit_val   <= pend;
            idle_tick <= tick_n;
        end
    end

    // R2: a bit only leaves the slicer after a sample of the line at mid
    a_r2_bit_after_mid: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> $past(!lvl_hi && !lvl_lo));
    // R8: the idle timeout and a bit strobe never coincide
    a_r8_tick_excl_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_tick && bit_stb));
endmodule

// File: rtl/trl_frame_fsm.sv
module trl_frame_fsm
    import trl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              idle_tick,
    output logic              frame_stb,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [DATA_W-1:0] frame_data
);
    localparam int NW = $clog2(BODY_W + 1);

    frame_st_t st, st_n;
    logic [NW-1:0]     cnt, cnt_n;
    logic [PRE_W-1:0]  pre, pre_n;
    logic [BODY_W-1:0] body, body_n;
    logic              stb_n;

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        pre_n  = pre;
        body_n = body;
        stb_n  = 1'b0;
        unique case (st)
            FR_IDLE: if (bit_stb) begin
                pre_n = {{(PRE_W-1){1'b0}}, bit_val};
                cnt_n = NW'(1);
                st_n  = FR_PRE;
            end
            FR_PRE: begin
                if (idle_tick) st_n = FR_IDLE;
                else if (bit_stb) begin
                    pre_n = {pre[PRE_W-2:0], bit_val};
                    if (cnt == NW'(PRE_W - 1)) begin
                        st_n  = (pre_n == SYNC_WORD) ? FR_BODY : FR_DROP;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + NW'(1);
                    end
                end
            end
            FR_BODY: begin
                if (idle_tick) st_n = FR_IDLE;
                else if (bit_stb) begin
                    body_n = {body[BODY_W-2:0], bit_val};
                    if (cnt == NW'(BODY_W - 1)) begin
                        stb_n = 1'b1;
                        st_n  = FR_IDLE;
                    end else begin
                        cnt_n = cnt + NW'(1);
                    end
                end
            end
            FR_DROP: if (idle_tick) st_n = FR_IDLE;
            default: st_n = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= FR_IDLE;
            cnt  <= '0;
            pre  <= '0;
            body <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            pre  <= pre_n;
            body <= body_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_stb  <= 1'b0;
            frame_addr <= '0;
            frame_data <= '0;
        end else begin
            frame_stb <= stb_n;
            if (stb_n) begin
                frame_addr <= body_n[BODY_W-1:DATA_W];
                frame_data <= body_n[DATA_W-1:0];
            end
        end
    end

    // R4: a frame is only emitted from the body-collection state
    a_r4_frame_from_body: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> $past(st == FR_BODY));
    // R3: a dropped frame never produces a frame strobe on the next cycle
    a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_DROP) |=> !frame_stb);
endmodule

// File: rtl/trl_pull_regs.sv
module trl_pull_regs
    import trl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              frame_stb,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [DATA_W-1:0] frame_data,
    output logic              commit_valid,
    output logic [WORD_W-1:0] commit_word
);
    logic [LO_W-1:0] lo_stage;
    logic hit_hi, hit_lo;

    assign hit_hi = frame_stb && (frame_addr == REG_HI);
    assign hit_lo = frame_stb && (frame_addr == REG_LO);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage     <= '0;
            commit_valid <= 1'b0;
            commit_word  <= '0;
        end else begin
            commit_valid <= hit_hi;
            if (hit_lo) lo_stage <= frame_data[LO_W-1:0];
            if (hit_hi) begin
                commit_word <= wide_mode ? {frame_data, lo_stage}
                                         : {{LO_W{1'b0}}, frame_data};
            end
        end
    end

    // R6: a commit lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> !commit_valid);
    // R5: a low-register write is not followed by a commit
    a_r5_lo_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_addr == REG_LO) |=> !commit_valid);
    // R7: narrow commits keep the top bits clear
    a_r7_narrow_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !$past(wide_mode)) |-> (commit_word[WORD_W-1:DATA_W] == '0));
endmodule

// File: rtl/trilevel_frame_rx.sv
module trilevel_frame_rx
    import trl_pkg::*;
#(
    parameter int MID_MIN    = 4,
    parameter int IDLE_LIMIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_hi,
    input  logic              lvl_lo,
    input  logic              wide_mode,
    output logic              commit_valid,
    output logic [WORD_W-1:0] commit_word
);
    logic bit_stb, bit_val, idle_tick, frame_stb;
    logic [ADDR_W-1:0] frame_addr;
    logic [DATA_W-1:0] frame_data;

    trl_bit_slicer #(.MID_MIN(MID_MIN), .IDLE_LIMIT(IDLE_LIMIT)) slicer_i (
        .clk(clk), .rst_n(rst_n), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .bit_stb(bit_stb), .bit_val(bit_val), .idle_tick(idle_tick)
    );

    trl_frame_fsm framer_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .idle_tick(idle_tick), .frame_stb(frame_stb),
        .frame_addr(frame_addr), .frame_data(frame_data)
    );

    trl_pull_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .frame_stb(frame_stb), .frame_addr(frame_addr), .frame_data(frame_data),
        .commit_valid(commit_valid), .commit_word(commit_word)
    );

    // R10: nothing is committed in the cycle right after reset is released
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !commit_valid);
endmodule

// File: tb/trilevel_frame_rx_tb.sv
module trilevel_frame_rx_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, lvl_hi, lvl_lo, wide_mode;
    logic commit_valid;
    logic [22:0] commit_word;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;
    logic [22:0] exp_q[$];
    string       tag_q[$];
    logic        prev_cv = 1'b0;

    trilevel_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .wide_mode(wide_mode), .commit_valid(commit_valid), .commit_word(commit_word)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_mid();
        lvl_hi = 1'b0; lvl_lo = 1'b0;
    endtask

    task automatic sym(bit b);
        lvl_hi = b; lvl_lo = !b;
        repeat (4) @(negedge clk);
        set_mid();
        repeat (8) @(negedge clk);
    endtask

    task automatic glitch();
        lvl_hi = 1'b1; lvl_lo = 1'b0;
        repeat (2) @(negedge clk);
        set_mid();
        repeat (2) @(negedge clk);
    endtask

    task automatic gap(int n);
        set_mid();
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(logic [15:0] pre, logic [7:0] addr, logic [15:0] data, bit glitchy);
        for (int i = 15; i >= 0; i--) sym(pre[i]);
        for (int i = 7; i >= 0; i--) sym(addr[i]);
        for (int i = 15; i >= 0; i--) begin
            if (glitchy) glitch();
            sym(data[i]);
        end
        gap(80);
    endtask

    task automatic expect_commit(logic [22:0] w, string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic drained(string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (commit_valid) begin
                if (prev_cv) check(1'b0, "R6 pulse longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 R5 R8 R9 unexpected commit", commit_word, 0);
                end else begin
                    logic [22:0] w;
                    string t;
                    w = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(commit_word === w, t, commit_word, w);
                end
            end
            prev_cv = commit_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wide_mode = 1'b1;
        set_mid();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(commit_valid == 1'b0, "R10 commit_valid after reset", commit_valid, 0);
        check(commit_word == 23'h0, "R10 commit_word after reset", commit_word, 0);
        gap(40);

        // R10 staged register is zero; R6 wide commit
        expect_commit({16'h139F, 7'h00}, "R10 R6 first commit with zero staged bits");
        send_frame(16'hFA0A, 8'h06, 16'h139F, 0);
        drained("R6 first commit seen");

        // R5: low write only stages
        send_frame(16'hFA0A, 8'h07, 16'h000A, 0);
        drained("R5 no commit on low write");
        expect_commit(23'h09CF8A, "R1 R4 R6 wide word with staged 0x0A");
        send_frame(16'hFA0A, 8'h06, 16'h139F, 0);
        drained("R6 commit after staging");

        send_frame(16'hFA0A, 8'h07, 16'h000B, 0);
        expect_commit(23'h5ECC0B, "R1 R6 negative word");
        send_frame(16'hFA0A, 8'h06, 16'hBD98, 0);
        drained("R6 negative word seen");

        // R9: other address ignored, staged bits kept
        send_frame(16'hFA0A, 8'h05, 16'hFFFF, 0);
        drained("R9 no commit on foreign address");
        expect_commit(23'h00008B, "R9 staged bits unchanged");
        send_frame(16'hFA0A, 8'h06, 16'h0001, 0);
        drained("R9 commit after foreign write");

        // R3: bad preamble
        send_frame(16'hFA0B, 8'h06, 16'h7777, 0);
        drained("R3 no commit on bad preamble");
        expect_commit(23'h11110B, "R3 recovery after bad preamble");
        send_frame(16'hFA0A, 8'h06, 16'h2222, 0);
        drained("R3 recovery frame seen");

        // R8: mid-frame timeout
        for (int i = 15; i >= 6; i--) sym(1'(16'hFA0A >> i));
        gap(80);
        drained("R8 partial frame discarded");
        expect_commit(23'h21908B, "R8 frame after timeout");
        send_frame(16'hFA0A, 8'h06, 16'h4321, 0);
        drained("R8 frame after timeout seen");

        // R2: glitches ahead of every data bit
        expect_commit(23'h09AB8B, "R2 glitches filtered");
        send_frame(16'hFA0A, 8'h06, 16'h1357, 1);
        drained("R2 glitch frame seen");

        // R7: narrow mode
        wide_mode = 1'b0;
        expect_commit(23'h00ABCD, "R7 narrow word");
        send_frame(16'hFA0A, 8'h06, 16'hABCD, 0);
        drained("R7 narrow commit seen");

        done = 1;
        summary();
        $finish;
    end
endmodule